// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a single-word-per-line cache in front of a slower memory. The line store is treated as two equal halves. Every address has a home line, chosen by its index bits, and a partner line in the opposite half, reached by inverting the top index bit. A lookup first checks the home line. If that misses, it checks the partner line one cycle later. Only when both checks fail does it go to memory. A hit at home answers faster than a hit at the partner, so the CPU side uses a valid/ready request and a response strobe, and accepts either latency.

A block found at its partner line swaps places with the home occupant, so the next access to it is a fast hit. A block fetched from memory is installed at home, and the previous home occupant moves to the partner line. Writes go straight through to memory. A write updates a cached copy it finds, but a write that misses allocates nothing. Each response carries a two-bit outcome code (home hit, partner hit, miss), so a performance counter can sort accesses by latency class.

The memory port issues one single-cycle request strobe. It then waits for a response strobe, which memory returns a fixed number of cycles later, whatever that number is.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address is a miss. While idle after reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: A read that hits its home line returns rsp_valid with status 2'b01 and the stored data on the second rising edge after the accepting edge.
- R3: The partner of index i is i with its top bit inverted. Each line stores the tag together with the top index bit of its owner, so a block in a line never matches an address whose home is that line unless it is the same address.
- R4: A read that misses at home and hits at the partner returns status 2'b10 and the correct data one edge later than a home hit, on the third edge after acceptance.
- R5: After a partner hit the two lines are exchanged. The next access to that address is a home hit, and the block that held the home line is now a partner hit.
- R6: A read that misses both lines issues one memory read for the request address. On the edge after mem_rsp_valid, the cache returns status 2'b11 and the memory data. It installs the block at home, moves the former home contents (valid bit included) to the partner line, and drops the former partner contents.
- R7: Every write issues exactly one memory write carrying the request address and data. The response comes on the edge after mem_rsp_valid, with the status of the lookup (2'b01, 2'b10 or 2'b11).
- R8: A write that hits updates the cached data. A write that hits at the partner also performs the R5 exchange. A later read returns the written value.
- R9: A write that misses both lines leaves the lines unchanged, so a later read of that address is a miss.
- R10: req_ready is 1 only while idle, and a request is taken on an edge where req_valid and req_ready are both 1. mem_req_valid lasts one cycle. The cache waits for mem_rsp_valid whatever the memory latency.
- R11: rsp_status is 2'b00 whenever rsp_valid is 0, and non-zero whenever it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 01 home hit, 10 partner hit, 11 miss, 00 idle |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| mem_req_valid | output | 1 | One-cycle memory request strobe |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion strobe |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
Wrong placement state shows up as a wrong latency class, not as wrong data. A missed swap turns the next expected home hit into a partner hit one edge late, with status 10 instead of 01. A wrong eviction on fill shows up as an unexpected memory request several accesses later. The bench models the line contents itself and compares the response strobe, status, data and memory strobe on every cycle. Any misplacement is therefore reported at the first access that touches the affected pair of lines. A lost write-through is reported at once as a missing or wrong memory write.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_HIT    = 2'b01,
    ST_PSEUDO = 2'b10,
    ST_MISS   = 2'b11
  } pac_status_e;

  typedef enum logic [2:0] {
    FSM_IDLE  = 3'd0,
    FSM_HOME  = 3'd1,
    FSM_PART  = 3'd2,
    FSM_MREQ  = 3'd3,
    FSM_MWAIT = 3'd4
  } pac_state_e;

endpackage

// File: rtl/pac_line_array.sv
module pac_line_array #(
  parameter int IDX_W  = 4,
  parameter int STAG_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_valid,
  output logic [STAG_W-1:0] rd_a_tag,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_valid,
  output logic [STAG_W-1:0] rd_b_tag,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              w0_en,
  input  logic [IDX_W-1:0]  w0_idx,
  input  logic [STAG_W-1:0] w0_tag,
  input  logic [DATA_W-1:0] w0_data,
  input  logic              w1_en,
  input  logic [IDX_W-1:0]  w1_idx,
  input  logic              w1_valid,
  input  logic [STAG_W-1:0] w1_tag,
  input  logic [DATA_W-1:0] w1_data
);
  localparam int LINES = 1 << IDX_W;

  logic              valid_q [LINES];
  logic [STAG_W-1:0] tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel0, sel1;
    assign sel0 = w0_en && (w0_idx == IDX_W'(i));
    assign sel1 = w1_en && (w1_idx == IDX_W'(i));

    // valid bits are the only state cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (sel0) begin
        valid_q[i] <= 1'b1;
      end else if (sel1) begin
        valid_q[i] <= w1_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel0) begin
        tag_q[i]  <= w0_tag;
        data_q[i] <= w0_data;
      end else if (sel1) begin
        tag_q[i]  <= w1_tag;
        data_q[i] <= w1_data;
      end
    end
  end

  assign rd_a_valid = valid_q[rd_a_idx];
  assign rd_a_tag   = tag_q[rd_a_idx];
  assign rd_a_data  = data_q[rd_a_idx];
  assign rd_b_valid = valid_q[rd_b_idx];
  assign rd_b_tag   = tag_q[rd_b_idx];
  assign rd_b_data  = data_q[rd_b_idx];

endmodule

// File: rtl/pac_match.sv
module pac_match #(
  parameter int STAG_W = 9
) (
  input  logic              line_valid,
  input  logic [STAG_W-1:0] line_tag,
  input  logic [STAG_W-1:0] probe_tag,
  output logic              hit
);
  assign hit = line_valid && (line_tag == probe_tag);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        we,
  input  logic        home_hit,
  input  logic        part_hit,
  input  logic        mem_rsp_valid,
  output pac_state_e  state,
  output logic        ready,
  output logic        load_req,
  output logic        wr_hit,
  output logic        do_swap,
  output logic        do_fill,
  output logic        rsp_fire,
  output pac_status_e rsp_code,
  output logic        mem_req
);
  pac_state_e  state_q, state_d;
  pac_status_e code_q, code_d;

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    load_req = 1'b0;
    wr_hit   = 1'b0;
    do_swap  = 1'b0;
    do_fill  = 1'b0;
    rsp_fire = 1'b0;
    rsp_code = ST_NONE;
    unique case (state_q)
      FSM_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          state_d  = FSM_HOME;
        end
      end
      FSM_HOME: begin
        if (home_hit) begin
          code_d = ST_HIT;
          if (we) begin
            wr_hit  = 1'b1;
            state_d = FSM_MREQ;
          end else begin
            rsp_fire = 1'b1;
            rsp_code = ST_HIT;
            state_d  = FSM_IDLE;
          end
        end else begin
          state_d = FSM_PART;
        end
      end
      FSM_PART: begin
        if (part_hit) begin
          do_swap = 1'b1;
          code_d  = ST_PSEUDO;
          if (we) begin
            state_d = FSM_MREQ;
          end else begin
            rsp_fire = 1'b1;
            rsp_code = ST_PSEUDO;
            state_d  = FSM_IDLE;
          end
        end else begin
          code_d  = ST_MISS;
          state_d = FSM_MREQ;
        end
      end
      FSM_MREQ: begin
        state_d = FSM_MWAIT;
      end
      FSM_MWAIT: begin
        if (mem_rsp_valid) begin
          rsp_fire = 1'b1;
          rsp_code = code_q;
          do_fill  = !we;
          state_d  = FSM_IDLE;
        end
      end
      default: state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      code_q  <= ST_NONE;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign state   = state_q;
  assign ready   = (state_q == FSM_IDLE);
  assign mem_req = (state_q == FSM_MREQ);

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  // stored tag = address tag plus top index bit of the owning address
  localparam int STAG_W = ADDR_W - IDX_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  // request holding registers
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              load_req;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   we_q <= 1'b0;
    else if (load_req) we_q <= req_we;
  end
  always_ff @(posedge clk) begin
    if (load_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  logic [IDX_W-1:0]  home_idx, part_idx;
  logic [STAG_W-1:0] probe_tag;
  assign home_idx  = addr_q[IDX_W-1:0];
  assign part_idx  = {~addr_q[IDX_W-1], addr_q[IDX_W-2:0]};
  assign probe_tag = addr_q[ADDR_W-1:IDX_W-1];

  // line store
  logic              home_v, part_v;
  logic [STAG_W-1:0] home_tag, part_tag;
  logic [DATA_W-1:0] home_data, part_data;
  logic              w0_en, w1_en;
  logic [DATA_W-1:0] w0_data;

  pac_line_array #(.IDX_W(IDX_W), .STAG_W(STAG_W), .DATA_W(DATA_W)) lines_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .rd_a_idx  (home_idx),
    .rd_a_valid(home_v),
    .rd_a_tag  (home_tag),
    .rd_a_data (home_data),
    .rd_b_idx  (part_idx),
    .rd_b_valid(part_v),
    .rd_b_tag  (part_tag),
    .rd_b_data (part_data),
    .w0_en     (w0_en),
    .w0_idx    (home_idx),
    .w0_tag    (probe_tag),
    .w0_data   (w0_data),
    .w1_en     (w1_en),
    .w1_idx    (part_idx),
    .w1_valid  (home_v),
    .w1_tag    (home_tag),
    .w1_data   (home_data)
  );

  // tag compare for the two probe positions
  logic [1:0]        probe_v;
  logic [STAG_W-1:0] probe_line_tag [2];
  logic [1:0]        probe_hit;
  assign probe_v           = {part_v, home_v};
  assign probe_line_tag[0] = home_tag;
  assign probe_line_tag[1] = part_tag;

  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_match #(.STAG_W(STAG_W)) match_i (
      .line_valid(probe_v[p]),
      .line_tag  (probe_line_tag[p]),
      .probe_tag (probe_tag),
      .hit       (probe_hit[p])
    );
  end

  // sequencing
  pac_state_e  state;
  pac_status_e rsp_code;
  logic        ready, wr_hit, do_swap, do_fill, rsp_fire, mem_req;

  pac_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .req_valid    (req_valid && req_ready),
    .we           (we_q),
    .home_hit     (probe_hit[0]),
    .part_hit     (probe_hit[1]),
    .mem_rsp_valid(mem_rsp_valid),
    .state        (state),
    .ready        (ready),
    .load_req     (load_req),
    .wr_hit       (wr_hit),
    .do_swap      (do_swap),
    .do_fill      (do_fill),
    .rsp_fire     (rsp_fire),
    .rsp_code     (rsp_code),
    .mem_req      (mem_req)
  );

  // line updates: port 0 always targets home, port 1 the partner
  always_comb begin
    w0_en   = wr_hit || do_swap || do_fill;
    w1_en   = do_swap || do_fill;
    w0_data = wdata_q;
    if (do_swap && !we_q) w0_data = part_data;
    if (do_fill)          w0_data = mem_rsp_rdata;
  end

  // response registers
  logic              rsp_valid_q;
  pac_status_e       rsp_status_q;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  always_comb begin
    rsp_rdata_d = '0;
    if (!we_q) begin
      unique case (state)
        FSM_HOME: rsp_rdata_d = home_data;
        FSM_PART: rsp_rdata_d = part_data;
        default:  rsp_rdata_d = mem_rsp_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_NONE;
    end else begin
      rsp_valid_q  <= rsp_fire;
      rsp_status_q <= rsp_fire ? rsp_code : ST_NONE;
    end
  end
  always_ff @(posedge clk) begin
    if (rsp_fire) rsp_rdata_q <= rsp_rdata_d;
  end

  assign req_ready     = ready && core_rst_n;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_status    = rsp_status_q;
  assign rsp_rdata     = rsp_rdata_q;
  assign mem_req_valid = mem_req;
  assign mem_req_we    = we_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_we,
  input logic       rsp_valid,
  input logic [1:0] rsp_status,
  input logic       mem_req_valid,
  input logic       mem_req_we,
  input logic       mem_rsp_valid
);
  logic cur_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cur_we <= 1'b0;
    else if (req_valid && req_ready) cur_we <= req_we;
  end

  AST_IDLE_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_status == 2'b00); // R11
  AST_RSP_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b00); // R11
  AST_HOME_HIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cur_we && rsp_status == 2'b01) |-> $past(req_valid && req_ready, 2)); // R2
  AST_PART_HIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cur_we && rsp_status == 2'b10) |-> $past(req_valid && req_ready, 3)); // R4
  AST_MISS_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b11) |-> $past(mem_rsp_valid)); // R6
  AST_WRITE_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cur_we) |-> $past(mem_rsp_valid)); // R7
  AST_MEM_KIND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_we == cur_we); // R7
  AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R10

endmodule

bind pseudo_assoc_cache pac_cache_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_we       (req_we),
  .rsp_valid    (rsp_valid),
  .rsp_status   (rsp_status),
  .mem_req_valid(mem_req_valid),
  .mem_req_we   (mem_req_we),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pseudo_assoc_cache_tb_top.sv
`timescale 1ns/1ps
module pseudo_assoc_cache_tb_top;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [1:0]        rsp_status;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_req_valid, mem_req_we;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_rdata;

  always #2.5 clk = ~clk;

  pseudo_assoc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (.*);

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  bit          mv [LINES];
  int          mt [LINES];
  logic [31:0] md [LINES];
  logic [31:0] mem_q [int];
  int          mem_lat = 3;
  int          mem_cnt = 0;
  logic [31:0] mem_pend;

  function automatic logic [31:0] mem_rd(int a);
    if (mem_q.exists(a)) return mem_q[a];
    return 32'h5A00_0000 ^ (a * 32'h0001_0203 + 7);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_step();
    mem_rsp_valid = 1'b0;
    if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem_pend;
      end
    end
    if (mem_req_valid) begin
      if (mem_req_we) mem_q[int'(mem_req_addr)] = mem_req_wdata;
      else            mem_pend = mem_rd(int'(mem_req_addr));
      mem_cnt = mem_lat;
    end
  endtask

  // one request, checked on every cycle until its response
  task automatic do_req(bit we, int addr, logic [31:0] wd, string req);
    int idx = addr % LINES;
    int alt = idx ^ (LINES / 2);
    int stag = addr >> (IDX_W - 1);
    int outc, km, lat;
    logic [31:0] exp_d = '0;
    bit tv; int tt; logic [31:0] td;
    if (mv[idx] && mt[idx] == stag)      outc = 1;
    else if (mv[alt] && mt[alt] == stag) outc = 2;
    else                                 outc = 3;
    case (outc)
      1: begin
        exp_d = md[idx];
        if (we) md[idx] = wd;
      end
      2: begin
        exp_d = md[alt];
        tv = mv[idx]; tt = mt[idx]; td = md[idx];
        mv[idx] = 1; mt[idx] = stag; md[idx] = we ? wd : md[alt];
        mv[alt] = tv; mt[alt] = tt; md[alt] = td;
      end
      default: begin
        if (!we) begin
          exp_d = mem_rd(addr);
          mv[alt] = mv[idx]; mt[alt] = mt[idx]; md[alt] = md[idx];
          mv[idx] = 1; mt[idx] = stag; md[idx] = exp_d;
        end
      end
    endcase
    if (!we && outc == 1)      begin km = 0; lat = 2; end
    else if (!we && outc == 2) begin km = 0; lat = 3; end
    else begin
      km  = (we && outc == 1) ? 2 : 3;
      lat = km + mem_lat + 1;
    end
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1; req_we = we; req_addr = ADDR_W'(addr); req_wdata = wd;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      chk(rsp_valid == (k == lat), {req, " rsp_valid timing"}, rsp_valid, (k == lat));
      chk(req_ready == (k == lat), "R10 ready only when idle", req_ready, (k == lat));
      chk(mem_req_valid == (k == km), "R10 mem strobe timing", mem_req_valid, (k == km));
      if (k != lat) chk(rsp_status == 2'b00, "R11 status idle", rsp_status, 0);
      if (k == km) begin
        chk(mem_req_addr == ADDR_W'(addr), "R7 mem address", mem_req_addr, addr);
        chk(mem_req_we == we, "R7 mem kind", mem_req_we, we);
        if (we) chk(mem_req_wdata == wd, "R7 mem write data", mem_req_wdata, wd);
      end
      if (k == lat) begin
        chk(rsp_status == 2'(outc), {req, " status"}, rsp_status, outc);
        if (!we) chk(rsp_rdata == exp_d, {req, " data"}, rsp_rdata, exp_d);
      end
      mem_step();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    mem_rsp_valid = 0; mem_rsp_rdata = '0; mem_cnt = 0;
    for (int i = 0; i < LINES; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 no mem request after reset", mem_req_valid, 0);
    chk(rsp_status == 2'b00, "R11 status after reset", rsp_status, 0);
  endtask

  localparam int A = 12'h012;  // index 2, tag 1
  localparam int B = 12'h01A;  // index 10 = partner of 2, tag 1
  localparam int C = 12'h022;  // index 2, tag 2
  localparam int D = 12'h035;  // index 5

  initial begin
    int seed;
    do_reset();
    do_req(0, A, 0, "R1 cold miss");
    do_req(0, A, 0, "R2 home hit");
    do_req(0, C, 0, "R6 miss displaces home");
    do_req(0, A, 0, "R4 partner hit");
    do_req(0, A, 0, "R5 hit after swap");
    do_req(0, C, 0, "R5 old home now partner");
    do_req(0, B, 0, "R3 no alias across halves");
    do_req(0, C, 0, "R6 former partner dropped");
    do_req(1, A, 32'hCAFE_0001, "R8 write partner hit");
    do_req(0, A, 0, "R8 read after write");
    do_req(1, A, 32'hCAFE_0002, "R7 write home hit");
    do_req(0, A, 0, "R8 read home written");
    do_req(1, D, 32'h1234_5678, "R9 write miss");
    do_req(0, D, 0, "R9 read after write miss");
    // mixed traffic over a few conflicting pairs
    seed = 17;
    for (int n = 0; n < 80; n++) begin
      int tg, ix, ad;
      seed = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
      tg = 1 + ((seed >> 8) % 3);
      ix = ((seed >> 4) & 1) ? 13 : 5;
      if ((seed >> 12) & 1) ix = ix ^ (LINES / 2);
      ad = (tg << IDX_W) | ix;
      if (n == 40) mem_lat = 7;
      do_req(((seed >> 16) % 4) == 0, ad, 32'(seed), "R5 mixed traffic");
    end
    mem_lat = 3;
    do_reset();
    do_req(0, A, 0, "R1 miss after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule